// File: doc/BRIEF.md
# Zero-Crossing Gated Digital Volume Stage

This block scales a stream of signed 16-bit audio samples by a selectable gain before they reach a DAC. There are 32 levels, addressed by a 5-bit code, on a uniform 1.5 dB grid. The grid runs from +12 dB of amplification at code 0 down to -34.5 dB at code 31, with code 8 at unity. Each sample is multiplied by an unsigned Q4.12 coefficient, rounded to nearest and clipped to the signed 16-bit range.

A level written by the control side does not take effect at once, because a sudden step in gain would be audible. The request is held as pending until the audio stream passes through zero, and the new gain then starts on that very sample. If the signal stays on one side of zero for 256 frames, the pending level is applied anyway. A second request made while one is pending replaces it and starts the timeout again.

Top module: `zcv_volume`

## Requirements
- R1: Code k selects a gain of (12 - 1.5*k) dB. The coefficient is round(4096 * 10^(gain/20)) in unsigned Q4.12. Code 0 is +12 dB, code 8 is exactly 4096 (unity) and code 31 is -34.5 dB.
- R2: A valid output equals floor((sample*coef + 2048) / 4096), saturated to the range -32768..32767.
- R3: out_vld is high exactly one cycle after each cycle with smp_vld high. In cycles that follow a cycle without smp_vld, out_smp holds its previous value.
- R4: While rst is high, out_vld and out_smp are 0, the active level is code 8 and no request is pending. The previous sample is taken as non-negative.
- R5: After a level write, valid samples keep the previous active gain until a zero crossing or the timeout occurs.
- R6: A valid sample is a zero crossing when it equals 0 or when its sign bit (bit 15) differs from that of the previous valid sample. With a request pending, that sample is already scaled by the requested level, which then becomes active.
- R7: If no crossing occurs, the 256th valid sample after the request is scaled by the requested level, which then becomes active.
- R8: A write made while a request is pending replaces the pending code and restarts the 256-sample count.
- R9: A sample presented in the same cycle as a level write is scaled with the state in force before that write. The write's count begins with the next valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Strobe marking a valid input sample |
| smp_in | input | 16 | Signed input sample |
| lvl_wr | input | 1 | Strobe for a new level request |
| lvl_code | input | 5 | Requested level code (0 = +12 dB, 31 = -34.5 dB) |
| out_vld | output | 1 | Strobe marking a valid output sample |
| out_smp | output | 16 | Scaled, saturated signed output sample |

## Verification
Each scaled sample appears on out_smp at the rising edge that follows its strobe. A level write touches only internal state at its own edge, so its effect is first visible on the output of the next valid sample that meets the crossing or timeout condition. The bench drives every input at a falling edge and compares the outputs at the next falling edge. Its expected values come from a cycle-by-cycle reference model of the pending level, the crossing test and the 256-sample counter. Directed runs place the forced update on exactly the 256th sample, after both a plain request and a replaced one.

// File: rtl/zcv_pkg.sv
package zcv_pkg;

    localparam int SMP_W          = 16;
    localparam int CODE_W         = 5;
    localparam int NUM_LVL        = 2 ** CODE_W;
    localparam int COEF_W         = 16;
    localparam int COEF_FRAC      = 12;
    localparam int UNITY_CODE     = 8;
    localparam int TIMEOUT_FRAMES = 256;

    localparam real TOP_GAIN_DB = 12.0;
    localparam real STEP_DB     = 1.5;

    typedef logic signed [SMP_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]       code_t;
    typedef logic [COEF_W-1:0]       coef_t;

    typedef struct packed {
        logic  pend;
        code_t pcode;
        code_t act;
        logic  prev_neg;
    } lvl_state_t;

    // Q4.12 coefficient for a level code, evaluated at elaboration time only
    function automatic coef_t level_coef(int code);
        real db;
        real lin;
        db  = TOP_GAIN_DB - STEP_DB * real'(code);
        lin = 10.0 ** (db / 20.0);
        return coef_t'($rtoi(lin * real'(2 ** COEF_FRAC) + 0.5));
    endfunction

endpackage

// File: rtl/zcv_gain_lut.sv
module zcv_gain_lut
    import zcv_pkg::*;
(
    input  code_t code,
    output coef_t coef
);

    coef_t tab [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam coef_t C = level_coef(g);
        assign tab[g] = C;
    end

    assign coef = tab[code];

endmodule

// File: rtl/zcv_scaler.sv
module zcv_scaler
    import zcv_pkg::*;
#(
    parameter int DW   = SMP_W,
    parameter int CWID = COEF_W,
    parameter int FRAC = COEF_FRAC
) (
    input  logic signed [DW-1:0] smp,
    input  logic [CWID-1:0]      coef,
    output logic signed [DW-1:0] res
);

    localparam int PW = DW + CWID + 1;
    localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC - 1));
    localparam logic signed [PW-1:0] SMAX = PW'(2 ** (DW - 1) - 1);
    localparam logic signed [PW-1:0] SMIN = -SMAX - PW'(1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        prod = PW'(smp) * PW'($signed({1'b0, coef}));
        rnd  = (prod + HALF) >>> FRAC;
        if (rnd > SMAX) begin
            res = {1'b0, {(DW-1){1'b1}}};
        end else if (rnd < SMIN) begin
            res = {1'b1, {(DW-1){1'b0}}};
        end else begin
            res = rnd[DW-1:0];
        end
    end

endmodule

// File: rtl/zcv_level_ctrl.sv
module zcv_level_ctrl
    import zcv_pkg::*;
#(
    parameter int DW      = SMP_W,
    parameter int TIMEOUT = TIMEOUT_FRAMES,
    parameter int UNITY   = UNITY_CODE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp,
    input  logic                 lvl_wr,
    input  code_t                lvl_code,
    output code_t                cur_code
);

    localparam int TW = $clog2(TIMEOUT);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    lvl_state_t    st;
    logic [TW-1:0] cnt;
    logic          zc;
    logic          apply;

    always_comb begin
        zc       = (smp == '0) || (smp[DW-1] != st.prev_neg);
        apply    = st.pend && smp_vld && (zc || cnt == LAST);
        cur_code = apply ? st.pcode : st.act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.pend     <= 1'b0;
            st.pcode    <= code_t'(UNITY);
            st.act      <= code_t'(UNITY);
            st.prev_neg <= 1'b0;
            cnt         <= '0;
        end else begin
            if (smp_vld) begin
                st.prev_neg <= smp[DW-1];
                if (apply) begin
                    st.act  <= st.pcode;
                    st.pend <= 1'b0;
                end else if (st.pend) begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (lvl_wr) begin
                st.pend  <= 1'b1;
                st.pcode <= lvl_code;
                cnt      <= '0;
            end
        end
    end

    // R5: with nothing pending and no write, the active level stays put
    a_r5_hold_level: assert property (@(posedge clk) disable iff (rst)
        (!st.pend && !lvl_wr) |=> $stable(st.act));

    // R6: a zero-valued sample resolves a pending request
    a_r6_zero_applies: assert property (@(posedge clk) disable iff (rst)
        (st.pend && smp_vld && smp == '0 && !lvl_wr) |=> (!st.pend && st.act == $past(st.pcode)));

    // R7: the last counted sample forces the pending level
    a_r7_forced_update: assert property (@(posedge clk) disable iff (rst)
        (st.pend && smp_vld && !lvl_wr && cnt == LAST) |=> (!st.pend && st.act == $past(st.pcode)));

    // R8: a write always leaves a fresh pending request
    a_r8_replace_pending: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> (st.pend && st.pcode == $past(lvl_code) && cnt == '0));

endmodule

// File: rtl/zcv_volume.sv
module zcv_volume
    import zcv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_vld,
    input  logic signed [15:0] smp_in,
    input  logic               lvl_wr,
    input  logic [4:0]         lvl_code,
    output logic               out_vld,
    output logic signed [15:0] out_smp
);

    code_t   cur_code;
    coef_t   coef;
    sample_t scaled;

    zcv_level_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp      (smp_in),
        .lvl_wr   (lvl_wr),
        .lvl_code (lvl_code),
        .cur_code (cur_code)
    );

    zcv_gain_lut u_lut (
        .code (cur_code),
        .coef (coef)
    );

    zcv_scaler u_scale (
        .smp  (smp_in),
        .coef (coef),
        .res  (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_smp <= '0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) begin
                out_smp <= scaled;
            end
        end
    end

    // R3: one registered stage between strobe and result
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> out_vld);

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> (!out_vld && $stable(out_smp)));

    // R1: the unity code passes samples through unchanged
    a_r1_unity_passthrough: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && cur_code == code_t'(UNITY_CODE)) |=> (out_smp == $past(smp_in)));

endmodule

// File: tb/tb_zcv_volume.sv
module tb_zcv_volume;

    logic               clk = 1'b0;
    logic               rst;
    logic               smp_vld;
    logic signed [15:0] smp_in;
    logic               lvl_wr;
    logic [4:0]         lvl_code;
    logic               out_vld;
    logic signed [15:0] out_smp;

    always #5 clk = ~clk;

    zcv_volume dut (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp_in   (smp_in),
        .lvl_wr   (lvl_wr),
        .lvl_code (lvl_code),
        .out_vld  (out_vld),
        .out_smp  (out_smp)
    );

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int m_act   = 8;
    int m_pcode = 8;
    int m_cnt   = 0;
    bit m_pend  = 1'b0;
    bit m_pneg  = 1'b0;
    int m_last  = 0;

    function automatic int coef_f(int c);
        real g;
        g = 10.0 ** ((12.0 - 1.5 * real'(c)) / 20.0);
        return $rtoi(g * 4096.0 + 0.5);
    endfunction

    function automatic int scale_f(int s, int c);
        longint p;
        p = longint'(s) * longint'(coef_f(c));
        p = (p + 2048) >>> 12;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return int'(p);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: inputs set at a falling edge, result checked at the next one
    task automatic step(string tag, bit v, int s, bit w, int c);
        int  use_c;
        bit  ap;
        int  expv;
        smp_vld  = v;
        smp_in   = 16'(s);
        lvl_wr   = w;
        lvl_code = 5'(c);
        use_c = m_act;
        ap    = 1'b0;
        if (v && m_pend && (s == 0 || ((s < 0) != m_pneg) || m_cnt == 255)) begin
            use_c = m_pcode;
            ap    = 1'b1;
        end
        expv = v ? scale_f(s, use_c) : m_last;
        if (v) begin
            if (ap) begin
                m_act  = m_pcode;
                m_pend = 1'b0;
            end else if (m_pend) begin
                m_cnt++;
            end
            m_pneg = (s < 0);
        end
        if (w) begin
            m_pend  = 1'b1;
            m_pcode = c;
            m_cnt   = 0;
        end
        m_last = expv;
        @(negedge clk);
        check(tag, int'(out_vld), int'(v));
        check(tag, int'(out_smp), expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        rst = 1'b1; smp_vld = 1'b0; smp_in = '0; lvl_wr = 1'b0; lvl_code = '0;
        @(negedge clk);
        @(negedge clk);
        check("R4 reset vld", int'(out_vld), 0);
        check("R4 reset smp", int'(out_smp), 0);
        rst = 1'b0;

        // R4: reset level is unity
        step("R4", 1, 1234, 0, 0);
        step("R4", 1, -777, 0, 0);
        step("R3", 0, 55, 0, 0);

        // R1: every code, applied through a zero sample, then probed with 4096
        for (int c = 0; c < 32; c++) begin
            step("R1", 0, 0, 1, c);
            step("R1", 1, 0, 0, 0);
            step("R1", 1, 4096, 0, 0);
            step("R1", 1, 1000, 0, 0);
        end

        // R2: saturation at +12 dB and rounding at odd values
        step("R2", 1, 0, 1, 0);
        step("R2", 1, 0, 0, 0);
        step("R2", 1, 32767, 0, 0);
        step("R2", 1, -32768, 0, 0);
        step("R2", 1, 9000, 0, 0);
        step("R2", 1, -9000, 0, 0);
        step("R2", 1, 3, 0, 0);
        step("R2", 1, 0, 1, 31);
        step("R2", 1, 0, 0, 0);
        step("R2", 1, 1, 0, 0);
        step("R2", 1, -32768, 0, 0);

        // R5/R7: positive run, forced at the 256th sample
        step("R5", 1, 0, 1, 8);
        step("R5", 1, 0, 0, 0);
        step("R5", 1, 1000, 0, 0);
        step("R5", 0, 0, 1, 2);
        for (int i = 0; i < 255; i++) step("R5", 1, 1000 + i, 0, 0);
        step("R7", 1, 1000, 0, 0);
        step("R7", 1, 1000, 0, 0);

        // R8: replacement restarts the count
        step("R8", 0, 0, 1, 4);
        for (int i = 0; i < 100; i++) step("R8", 1, 500, 0, 0);
        step("R8", 0, 0, 1, 20);
        for (int i = 0; i < 255; i++) step("R8", 1, 500, 0, 0);
        step("R8", 1, 500, 0, 0);
        step("R8", 1, 500, 0, 0);

        // R6: sign change both ways
        step("R6", 1, 800, 1, 10);
        step("R6", 1, 900, 0, 0);
        step("R6", 1, -300, 0, 0);
        step("R6", 1, -400, 1, 6);
        step("R6", 1, -50, 0, 0);
        step("R6", 1, 60, 0, 0);

        // R9: write and zero sample in the same cycle
        step("R9", 1, 0, 1, 0);
        step("R9", 1, 700, 0, 0);
        step("R9", 1, 0, 0, 0);
        step("R9", 1, 700, 0, 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit v;
            bit w;
            int s;
            int sel;
            v   = ($urandom % 4) != 0;
            w   = ($urandom % 48) == 0;
            sel = $urandom % 16;
            if (sel == 0)      s = 0;
            else if (sel == 1) s = 32767;
            else if (sel == 2) s = -32768;
            else if (sel < 8)  s = int'($urandom % 2000);
            else               s = int'($urandom % 65536) - 32768;
            step("R2 random", v, s, w, int'($urandom % 32));
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule